// File: doc/BRIEF.md
# Dual H-Bridge PWM Command Driver

The block drives two H-bridges. Each bridge takes four gate lines, named A, B, C and D. One 8-bit command byte sets the speed, the direction and the brake of one channel. A strobe marks the byte as valid. A PWM phase counter is shared by both channels and moves one step on each cycle where the tick enable is high.

On each tick the block compares the phase with the stored speed of each channel. The channel's high-phase pattern or its coast pattern is then written into a registered 8-bit output. Channel 0 drives the low nibble and channel 1 drives the high nibble.

The block keeps a ready-made pair of output patterns for each channel. These are the coast pattern for the low phase and the drive or brake pattern for the high phase. The per-tick work is therefore only one compare and one select. A command rewrites the speed and both patterns of its channel in one clock edge. Because the low phase always coasts, braking has a variable strength set by the speed field, in the same way as forward and reverse drive.

Top module: `hbridge_pwm_driver`

## Requirements
- R1: While reset is high and afterwards, until a command has been accepted, gate_out is 8'h00 on every tick.
- R2: The phase counter is 0 after reset. On each tick_en cycle it advances to 1, 2, … 15 and then wraps to 1, which gives a period of 15 ticks.
- R3: A channel is in its high phase on a tick when its speed field is greater than or equal to the new phase value. Speed 0 never enters the high phase, and speed 15 is in the high phase on every tick.
- R4: The nibble value is written A,B,C,D from bit 3 down to bit 0. The high-phase nibble is 4'b1010 when direction bit 5 is 0 (forward) and 4'b0101 when bit 5 is 1 (reverse).
- R5: When brake bit 4 is 1, the high-phase nibble is 4'b0000 whatever the value of bit 5.
- R6: Once a channel has received a command, its low-phase nibble is 4'b0011 (coast).
- R7: Bit 6 of cmd_byte selects the channel: 0 writes channel 0, which drives gate_out[3:0], and 1 writes channel 1, which drives gate_out[7:4]. Bit 7 is ignored. The channel that is not selected keeps its settings.
- R8: gate_out changes only on the clock edge of a tick_en cycle, and both nibbles change in that same edge. A command accepted in a tick_en cycle first affects the output on the next tick. A command accepted with no tick leaves gate_out unchanged until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Advances the PWM phase and refreshes the output |
| cmd_valid | input | 1 | Marks cmd_byte as valid in this cycle |
| cmd_byte | input | 8 | Command: bit 6 channel, bit 5 direction, bit 4 brake, bits 3:0 speed |
| gate_out | output | 8 | Registered gate patterns: [3:0] channel 0, [7:4] channel 1 |

## Verification
A command write and a PWM tick can fall in the same cycle. When they do, the tick must use the channel's old settings and the new settings must show from the following tick onward. The bench provokes this by raising cmd_valid together with tick_en, and also by sending commands on cycles with no tick between two ticks. A scoreboard that models the phase and the settings judges every cycle, so both an early use of a new command and any output change between ticks are caught.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int SPEED_W   = 4;
    localparam int PAT_W     = 4;
    localparam int CH_NUM    = 2;
    localparam int CMD_W     = 8;
    localparam int OUT_W     = PAT_W * CH_NUM;
    localparam int PHASE_MAX = (1 << SPEED_W) - 1;

    // Command field positions (decoded by this block)
    localparam int CMD_CH_BIT  = 6;
    localparam int CMD_DIR_BIT = 5;
    localparam int CMD_BRK_BIT = 4;

    typedef logic [SPEED_W-1:0] speed_t;
    typedef logic [PAT_W-1:0]   pat_t;
    typedef logic [CMD_W-1:0]   cmd_t;

    // Gate patterns, A in bit 3 down to D in bit 0
    localparam pat_t PAT_FWD   = 4'b1010;
    localparam pat_t PAT_REV   = 4'b0101;
    localparam pat_t PAT_BRAKE = 4'b0000;
    localparam pat_t PAT_COAST = 4'b0011;

    typedef enum logic [1:0] {
        DRV_FWD   = 2'd0,
        DRV_REV   = 2'd1,
        DRV_BRAKE = 2'd2
    } drive_e;

    typedef struct packed {
        speed_t speed;
        pat_t   pat_low;
        pat_t   pat_high;
    } chan_cfg_t;

    function automatic drive_e cmd_drive(input cmd_t c);
        if (c[CMD_BRK_BIT])
            return DRV_BRAKE;
        else if (c[CMD_DIR_BIT])
            return DRV_REV;
        else
            return DRV_FWD;
    endfunction

    function automatic pat_t drive_pattern(input drive_e d);
        case (d)
            DRV_FWD:   return PAT_FWD;
            DRV_REV:   return PAT_REV;
            default:   return PAT_BRAKE;
        endcase
    endfunction

    function automatic chan_cfg_t cmd_to_cfg(input cmd_t c);
        chan_cfg_t r;
        r.speed    = c[SPEED_W-1:0];
        r.pat_low  = PAT_COAST;
        r.pat_high = drive_pattern(cmd_drive(c));
        return r;
    endfunction

    function automatic speed_t next_phase(input speed_t p);
        if (p == speed_t'(PHASE_MAX))
            return speed_t'(1);
        else
            return p + speed_t'(1);
    endfunction

endpackage

// File: rtl/hbd_cmd_decode.sv
module hbd_cmd_decode
    import hbd_pkg::*;
(
    input  logic                   cmd_valid,
    input  cmd_t                   cmd_byte,
    output logic [CH_NUM-1:0]      wr_en,
    output chan_cfg_t              wr_cfg
);

    logic sel_bit;

    assign sel_bit = cmd_byte[CMD_CH_BIT];

    always_comb begin
        wr_cfg = cmd_to_cfg(cmd_byte);
    end

    for (genvar i = 0; i < CH_NUM; i++) begin : g_sel
        assign wr_en[i] = cmd_valid && (sel_bit == 1'(i));
    end

endmodule

// File: rtl/hbd_chan_store.sv
module hbd_chan_store
    import hbd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  chan_cfg_t wr_cfg,
    output chan_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= wr_cfg;
    end

endmodule

// File: rtl/hbd_phase_counter.sv
module hbd_phase_counter
    import hbd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    output speed_t phase_nxt,
    output speed_t phase_q
);

    assign phase_nxt = next_phase(phase_q);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (tick_en)
            phase_q <= phase_nxt;
    end

endmodule

// File: rtl/hbd_out_stage.sv
module hbd_out_stage
    import hbd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_en,
    input  speed_t                  phase_nxt,
    input  chan_cfg_t [CH_NUM-1:0]  cfg_all,
    output logic [OUT_W-1:0]        gate_out
);

    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        pat_t sel_pat;

        always_comb begin
            if (cfg_all[i].speed >= phase_nxt)
                sel_pat = cfg_all[i].pat_high;
            else
                sel_pat = cfg_all[i].pat_low;
        end

        always_ff @(posedge clk) begin
            if (rst)
                gate_out[i*PAT_W +: PAT_W] <= '0;
            else if (tick_en)
                gate_out[i*PAT_W +: PAT_W] <= sel_pat;
        end
    end

endmodule

// File: rtl/hbridge_pwm_driver.sv
module hbridge_pwm_driver
    import hbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic [7:0]       gate_out
);

    logic [CH_NUM-1:0]       wr_en;
    chan_cfg_t               wr_cfg;
    chan_cfg_t [CH_NUM-1:0]  cfg_all;
    speed_t                  phase_nxt;
    speed_t                  phase_q;

    hbd_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .wr_en     (wr_en),
        .wr_cfg    (wr_cfg)
    );

    for (genvar i = 0; i < CH_NUM; i++) begin : g_store
        hbd_chan_store u_store (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en[i]),
            .wr_cfg (wr_cfg),
            .cfg_q  (cfg_all[i])
        );
    end

    hbd_phase_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .phase_nxt (phase_nxt),
        .phase_q   (phase_q)
    );

    hbd_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .phase_nxt (phase_nxt),
        .cfg_all   (cfg_all),
        .gate_out  (gate_out)
    );

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
    import hbd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_en,
    input  logic                   cmd_valid,
    input  logic [7:0]             cmd_byte,
    input  logic [7:0]             gate_out,
    input  speed_t                 phase_q,
    input  chan_cfg_t [CH_NUM-1:0] cfg_all
);

    function automatic logic nib_legal(input pat_t n);
        return (n == PAT_FWD) || (n == PAT_REV) ||
               (n == PAT_BRAKE) || (n == PAT_COAST);
    endfunction

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> gate_out == 8'h00);

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && phase_q == speed_t'(PHASE_MAX)) |=> phase_q == speed_t'(1));

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && phase_q != speed_t'(PHASE_MAX)) |=> phase_q == speed_t'($past(phase_q) + speed_t'(1)));

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(phase_q));

    assert_brake_ch0_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[CMD_BRK_BIT] && !cmd_byte[CMD_CH_BIT]) |=> cfg_all[0].pat_high == PAT_BRAKE);

    assert_brake_ch1_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[CMD_BRK_BIT] && cmd_byte[CMD_CH_BIT]) |=> cfg_all[1].pat_high == PAT_BRAKE);

    assert_nibble_legal_R6: assert property (@(posedge clk) disable iff (rst)
        nib_legal(gate_out[3:0]) && nib_legal(gate_out[7:4]));

    assert_ch1_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_byte[CMD_CH_BIT]) |=> $stable(cfg_all[1]));

    assert_ch0_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[CMD_CH_BIT]) |=> $stable(cfg_all[0]));

    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(gate_out));

endmodule

bind hbridge_pwm_driver hbd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .gate_out  (gate_out),
    .phase_q   (phase_q),
    .cfg_all   (cfg_all)
);

// File: tb/test_hbridge_pwm_driver.sv
module test_hbridge_pwm_driver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] gate_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    hbridge_pwm_driver i_hbridge_pwm_driver (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .gate_out  (gate_out)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sbq[$];

    // Reference model state
    int         m_phase = 0;
    logic [7:0] m_out   = 8'h00;
    bit         m_seen [2];
    int         m_spd  [2];
    bit         m_dir  [2];
    bit         m_brk  [2];

    function automatic logic [3:0] model_nib(input int ch, input int p);
        if (!m_seen[ch]) return 4'b0000;
        if (m_spd[ch] >= p) begin
            if (m_brk[ch]) return 4'b0000;
            return m_dir[ch] ? 4'b0101 : 4'b1010;
        end
        return 4'b0011;
    endfunction

    task automatic step(input bit t, input bit v, input logic [7:0] b, input string tag);
        sb_item_t it;
        int ch;
        @(negedge clk);
        tick_en   = t;
        cmd_valid = v;
        cmd_byte  = b;
        if (t) begin
            m_phase = (m_phase == 15) ? 1 : m_phase + 1;
            m_out = {model_nib(1, m_phase), model_nib(0, m_phase)};
        end
        if (v) begin
            ch = b[6] ? 1 : 0;
            m_seen[ch] = 1;
            m_spd[ch]  = int'(b[3:0]);
            m_dir[ch]  = b[5];
            m_brk[ch]  = b[4];
        end
        it.exp = m_out;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1, 0, 8'h00, tag);
    endtask

    // Monitor: compares one item per cycle, away from the edge
    always @(posedge clk) begin
        sb_item_t it;
        #2;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_tests++;
            if (gate_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: gate_out=%h expected=%h", it.tag, gate_out, it.exp);
            end
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_seen[c] = 0; m_spd[c] = 0; m_dir[c] = 0; m_brk[c] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        n_tests++;
        if (gate_out !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: gate_out=%h expected=%h in reset", gate_out, 8'h00);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: idle ticks stay zero before any command
        ticks(20, "R1");

        // R2/R4/R6: channel 0 forward speed 8 over two periods
        step(0, 1, 8'h08, "R4");
        ticks(30, "R2");

        // R7: channel 1 reverse speed 5, bit 7 set and ignored
        step(0, 1, 8'hE5, "R7");
        ticks(15, "R7");

        // R5: channel 0 brake with reverse bit also set, speed 10
        step(0, 1, 8'h3A, "R5");
        ticks(15, "R5");

        // R3: channel 1 speed 0 forward, channel 0 speed 15 reverse
        step(0, 1, 8'h40, "R3");
        step(0, 1, 8'h2F, "R3");
        ticks(16, "R3");

        // R6: low phase coast on both channels, speed 1
        step(0, 1, 8'h01, "R6");
        step(0, 1, 8'h41, "R6");
        ticks(15, "R6");

        // R8: commands without tick leave output unchanged
        step(0, 1, 8'h0F, "R8");
        step(0, 1, 8'h5F, "R8");
        step(0, 0, 8'h00, "R8");
        ticks(2, "R8");
        // R8: command in the same cycle as a tick takes effect next tick
        step(1, 1, 8'h20, "R8");
        step(1, 1, 8'h6C, "R8");
        ticks(3, "R8");
        // R8: interleaved ticks and commands
        for (int k = 0; k < 40; k++) begin
            step(k[0], (k % 3) == 0, 8'(k * 37), "R8");
        end
        step(0, 0, 8'h00, "R8");
        ticks(16, "R2");
        step(0, 0, 8'h00, "R8");

        repeat (3) @(posedge clk);
        #3;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule